// File: doc/BRIEF.md
# Hierarchical Sub-Wordline Row Controller

This block drives the row-select controls of a memory array built from divided wordlines. The array is split into row blocks. Each row block owns four sub-decode lines, a block-select line, and a transfer-gate control on its left side and on its right side. The main wordlines are shared across all blocks. A sub-wordline fires only where its main wordline and one of the sub-decode lines of its block are both high.

A caller raises a request together with a row address, the retention-mode flag and a pulse length. The block accepts the request when it is idle. It splits the address into fields and first raises the block-level controls of the selected block. It then pulses one main wordline for the programmed number of clocks and finally gives a one-cycle done strobe. In normal mode the block-level controls drop after every access. In retention mode they stay up while successive refreshes stay inside the same row block, so only the main wordline switches. Two counters report how many transitions the sub-decode lines and the transfer-gate lines have made, which makes the saving visible.

Top module: `hsw_row_ctrl`

## Requirements
- R1: The row address splits into fields. Bits [1:0] pick the sub-decode line, bits [6:2] pick one of 32 main wordlines, and bits [8:7] pick one of 4 row blocks. Sub-decode line k of block b is bit b*4+k of the sub-decode output.
- R2: The main wordline `mwl_o[row[6:2]]` is the only main wordline high. It stays high for exactly `pulse_len_i` clocks, and a length of 0 counts as 1. No main wordline is high at any other time.
- R3: While the main wordline is high, exactly one block-select bit is high (the addressed block), and the left and right transfer-gate outputs both equal the block select.
- R4: In normal mode (`ret_mode_i` low when the request is taken), exactly one sub-decode line is high during the pulse. All sub-decode, block-select and transfer-gate outputs are low by the cycle in which done is high.
- R5: In retention mode, all four sub-decode lines, the block select and both transfer gates of the addressed block are raised. They stay high after done and do not move for later retention requests to the same block.
- R6: In retention mode, the first request whose block field differs from the held block drops the held controls and raises those of the new block.
- R7: When `ret_mode_i` is low while the block is idle and controls are held, every held control is low one clock later.
- R8: `done_o` is high for exactly one cycle, in the cycle right after the last main-wordline cycle. `busy_o` is high from the cycle after acceptance through done. A request raised while busy is ignored.
- R9: `sd_tog_o` counts every 0-to-1 and 1-to-0 change on each sub-decode bit. `tg_tog_o` counts the same on each left and right transfer-gate bit.
- R10: After reset, all control outputs, `busy_o`, `done_o` and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access/refresh request, taken when idle |
| row_i | input | 9 | Row address |
| ret_mode_i | input | 1 | Data-retention mode |
| pulse_len_i | input | 4 | Main wordline pulse length in clocks (0 means 1) |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion strobe |
| mwl_o | output | 32 | Main wordlines |
| sd_o | output | 16 | Sub-decode lines, four per row block |
| blk_sel_o | output | 4 | Row-block select |
| tg_l_o | output | 4 | Left transfer gate per row block |
| tg_r_o | output | 4 | Right transfer gate per row block |
| sd_tog_o | output | 16 | Sub-decode transition count |
| tg_tog_o | output | 16 | Transfer-gate transition count |

## Verification
Normal-mode accesses use the all-zeros and all-ones addresses and two mixed addresses, with pulse lengths of 0, 1, 3 and 5. These separate a swapped or shifted address field, a wrong pulse count and a lost zero-length case. A retention run of four refreshes inside one block, then one request to another block, then mode exit, shows whether controls are held, re-driven or released at the right moments. The transition counters are checked across each phase, and these counts differ between the held and the unheld behaviour. A second request raised during a busy access checks that it adds no extra pulse.

// File: rtl/rowctl_pkg.sv
package rowctl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_PULSE = 2'd2,
      ST_DONE  = 2'd3
   } seq_state_e;
endpackage

// File: rtl/rowctl_addr_dec.sv
module rowctl_addr_dec #(
   parameter int SD_W  = 2,
   parameter int MWL_W = 5,
   parameter int BLK_W = 2,
   localparam int ROW_W = SD_W + MWL_W + BLK_W
) (
   input  logic [ROW_W-1:0] row_i,
   output logic [SD_W-1:0]  sd_idx_o,
   output logic [MWL_W-1:0] mwl_idx_o,
   output logic [BLK_W-1:0] blk_idx_o
);
   // Low bits: sub-decode, middle: main wordline, top: row block
   assign sd_idx_o  = row_i[SD_W-1:0];
   assign mwl_idx_o = row_i[SD_W +: MWL_W];
   assign blk_idx_o = row_i[ROW_W-1 -: BLK_W];
endmodule

// File: rtl/rowctl_seq.sv
module rowctl_seq
   import rowctl_pkg::*;
#(
   parameter int PL_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_i,
   input  logic [PL_W-1:0] pulse_len_i,
   output logic            accept_o,
   output logic            pulse_on_o,
   output logic            pulse_end_o,
   output logic            idle_o,
   output logic            done_o
);
   seq_state_e      st_q;
   logic [PL_W-1:0] len_q;
   logic [PL_W-1:0] cnt_q;

   assign idle_o      = (st_q == ST_IDLE);
   assign accept_o    = idle_o && req_i;
   assign pulse_on_o  = (st_q == ST_PULSE);
   assign pulse_end_o = pulse_on_o && (cnt_q == '0);
   assign done_o      = (st_q == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         len_q <= '0;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (req_i) begin
               len_q <= (pulse_len_i == '0) ? PL_W'(1) : pulse_len_i;
               st_q  <= ST_SETUP;
            end
            ST_SETUP: begin
               cnt_q <= len_q - PL_W'(1);
               st_q  <= ST_PULSE;
            end
            ST_PULSE: begin
               if (cnt_q == '0) st_q <= ST_DONE;
               else             cnt_q <= cnt_q - PL_W'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R8
   done_follows_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_end_o |=> (done_o && !pulse_on_o));
endmodule

// File: rtl/rowctl_hold.sv
module rowctl_hold #(
   parameter int SD_W        = 2,
   parameter int BLK_W       = 2,
   parameter bit RET_HOLD_EN = 1'b1,
   localparam int NSD  = 1 << SD_W,
   localparam int NBLK = 1 << BLK_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept_i,
   input  logic                ret_mode_i,
   input  logic [BLK_W-1:0]    blk_idx_i,
   input  logic [SD_W-1:0]     sd_idx_i,
   input  logic                pulse_end_i,
   input  logic                idle_i,
   output logic [NBLK*NSD-1:0] sd_o,
   output logic [NBLK-1:0]     blk_sel_o,
   output logic [NBLK-1:0]     tg_l_o,
   output logic [NBLK-1:0]     tg_r_o,
   output logic                mode_o
);
   logic                ret_eff;
   logic [NBLK-1:0]     blk_hit;
   logic [NBLK*NSD-1:0] sd_one;
   logic [NBLK*NSD-1:0] sd_all;
   logic [NBLK*NSD-1:0] sd_q;
   logic [NBLK-1:0]     blk_q, tgl_q, tgr_q;
   logic                held_q, mode_q;
   logic [BLK_W-1:0]    held_blk_q;
   logic                same_blk;

   if (RET_HOLD_EN) begin : g_hold
      assign ret_eff = ret_mode_i;
   end else begin : g_nohold
      assign ret_eff = 1'b0;
   end

   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      assign blk_hit[b] = (blk_idx_i == BLK_W'(b));
      assign sd_one[b*NSD +: NSD] = blk_hit[b] ? (NSD'(1) << sd_idx_i) : '0;
      assign sd_all[b*NSD +: NSD] = {NSD{blk_hit[b]}};
   end

   assign same_blk = held_q && (held_blk_q == blk_idx_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sd_q       <= '0;
         blk_q      <= '0;
         tgl_q      <= '0;
         tgr_q      <= '0;
         held_q     <= 1'b0;
         mode_q     <= 1'b0;
         held_blk_q <= '0;
      end else if (accept_i) begin
         mode_q <= ret_eff;
         if (ret_eff) begin
            if (!same_blk) begin
               sd_q       <= sd_all;
               blk_q      <= blk_hit;
               tgl_q      <= blk_hit;
               tgr_q      <= blk_hit;
               held_q     <= 1'b1;
               held_blk_q <= blk_idx_i;
            end
         end else begin
            sd_q   <= sd_one;
            blk_q  <= blk_hit;
            tgl_q  <= blk_hit;
            tgr_q  <= blk_hit;
            held_q <= 1'b0;
         end
      end else if ((pulse_end_i && !mode_q) || (idle_i && !ret_eff && held_q)) begin
         sd_q   <= '0;
         blk_q  <= '0;
         tgl_q  <= '0;
         tgr_q  <= '0;
         held_q <= 1'b0;
      end
   end

   assign sd_o      = sd_q;
   assign blk_sel_o = blk_q;
   assign tg_l_o    = tgl_q;
   assign tg_r_o    = tgr_q;
   assign mode_o    = mode_q;

   // R5
   ret_same_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_i && ret_eff && same_blk) |=> ($stable(sd_q) && $stable(tgl_q) && $stable(tgr_q)));
   // R4
   normal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_end_i && !mode_q) |=> (sd_q == '0 && blk_q == '0 && tgl_q == '0 && tgr_q == '0));
   // R7
   exit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_i && !accept_i && !ret_mode_i && held_q) |=> (sd_q == '0 && blk_q == '0));
endmodule

// File: rtl/rowctl_tog_cnt.sv
module rowctl_tog_cnt #(
   parameter int IN_W  = 16,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IN_W-1:0]  vec_i,
   output logic [CNT_W-1:0] cnt_o
);
   logic [IN_W-1:0]  prev_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         cnt_q  <= '0;
      end else begin
         prev_q <= vec_i;
         cnt_q  <= cnt_q + CNT_W'($countones(vec_i ^ prev_q));
      end
   end

   assign cnt_o = cnt_q;

   // R9
   tog_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_i == prev_q) |=> $stable(cnt_q));
endmodule

// File: rtl/hsw_row_ctrl.sv
module hsw_row_ctrl #(
   parameter int SD_W        = 2,
   parameter int MWL_W       = 5,
   parameter int BLK_W       = 2,
   parameter int PL_W        = 4,
   parameter int CNT_W       = 16,
   parameter bit RET_HOLD_EN = 1'b1,
   localparam int ROW_W = SD_W + MWL_W + BLK_W,
   localparam int NSD   = 1 << SD_W,
   localparam int NMWL  = 1 << MWL_W,
   localparam int NBLK  = 1 << BLK_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_i,
   input  logic [ROW_W-1:0]    row_i,
   input  logic                ret_mode_i,
   input  logic [PL_W-1:0]     pulse_len_i,
   output logic                busy_o,
   output logic                done_o,
   output logic [NMWL-1:0]     mwl_o,
   output logic [NBLK*NSD-1:0] sd_o,
   output logic [NBLK-1:0]     blk_sel_o,
   output logic [NBLK-1:0]     tg_l_o,
   output logic [NBLK-1:0]     tg_r_o,
   output logic [CNT_W-1:0]    sd_tog_o,
   output logic [CNT_W-1:0]    tg_tog_o
);
   if (SD_W < 1 || SD_W > 3) begin : g_bad_sd
      $error("SD_W out of range");
   end
   if (MWL_W < 1 || MWL_W > 8) begin : g_bad_mwl
      $error("MWL_W out of range");
   end
   if (BLK_W < 1 || BLK_W > 6) begin : g_bad_blk
      $error("BLK_W out of range");
   end
   if (PL_W < 1 || CNT_W < 4) begin : g_bad_cnt
      $error("PL_W or CNT_W too small");
   end

   logic [SD_W-1:0]  sd_idx;
   logic [MWL_W-1:0] mwl_idx;
   logic [BLK_W-1:0] blk_idx;
   logic [MWL_W-1:0] mwl_idx_q;
   logic accept, pulse_on, pulse_end, idle, mode;

   rowctl_addr_dec #(.SD_W(SD_W), .MWL_W(MWL_W), .BLK_W(BLK_W)) u_dec (
      .row_i     (row_i),
      .sd_idx_o  (sd_idx),
      .mwl_idx_o (mwl_idx),
      .blk_idx_o (blk_idx)
   );

   rowctl_seq #(.PL_W(PL_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_i),
      .pulse_len_i (pulse_len_i),
      .accept_o    (accept),
      .pulse_on_o  (pulse_on),
      .pulse_end_o (pulse_end),
      .idle_o      (idle),
      .done_o      (done_o)
   );

   rowctl_hold #(.SD_W(SD_W), .BLK_W(BLK_W), .RET_HOLD_EN(RET_HOLD_EN)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept_i    (accept),
      .ret_mode_i  (ret_mode_i),
      .blk_idx_i   (blk_idx),
      .sd_idx_i    (sd_idx),
      .pulse_end_i (pulse_end),
      .idle_i      (idle),
      .sd_o        (sd_o),
      .blk_sel_o   (blk_sel_o),
      .tg_l_o      (tg_l_o),
      .tg_r_o      (tg_r_o),
      .mode_o      (mode)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mwl_idx_q <= '0;
      else if (accept) mwl_idx_q <= mwl_idx;
   end

   assign mwl_o  = pulse_on ? (NMWL'(1) << mwl_idx_q) : '0;
   assign busy_o = !idle;

   rowctl_tog_cnt #(.IN_W(NBLK*NSD), .CNT_W(CNT_W)) u_sd_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .vec_i (sd_o),
      .cnt_o (sd_tog_o)
   );

   rowctl_tog_cnt #(.IN_W(2*NBLK), .CNT_W(CNT_W)) u_tg_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .vec_i ({tg_l_o, tg_r_o}),
      .cnt_o (tg_tog_o)
   );

   // R2
   mwl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mwl_o));
   // R3
   tg_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mwl_o != '0) |-> ($onehot(blk_sel_o) && tg_l_o == blk_sel_o && tg_r_o == blk_sel_o));
   // R4
   normal_one_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mwl_o != '0 && !mode) |-> ($countones(sd_o) == 1));
   // R8
   mwl_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mwl_o != '0) |-> busy_o);
endmodule

// File: tb/tb_hsw_row_ctrl.sv
`timescale 1ns/1ps
module tb_hsw_row_ctrl;
   localparam int ROW_W = 9;
   localparam int NMWL  = 32;
   localparam int NBLK  = 4;
   localparam int NSDT  = 16;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             req_i = 1'b0;
   logic [ROW_W-1:0] row_i = '0;
   logic             ret_mode_i = 1'b0;
   logic [3:0]       pulse_len_i = '0;
   logic             busy_o, done_o;
   logic [NMWL-1:0]  mwl_o;
   logic [NSDT-1:0]  sd_o;
   logic [NBLK-1:0]  blk_sel_o, tg_l_o, tg_r_o;
   logic [15:0]      sd_tog_o, tg_tog_o;

   hsw_row_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .row_i(row_i),
      .ret_mode_i(ret_mode_i), .pulse_len_i(pulse_len_i),
      .busy_o(busy_o), .done_o(done_o), .mwl_o(mwl_o), .sd_o(sd_o),
      .blk_sel_o(blk_sel_o), .tg_l_o(tg_l_o), .tg_r_o(tg_r_o),
      .sd_tog_o(sd_tog_o), .tg_tog_o(tg_tog_o)
   );

   typedef struct {
      logic [NMWL-1:0] mwl;
      logic [NSDT-1:0] sd;
      logic [NBLK-1:0] blk;
      int              len;
   } exp_t;

   exp_t q[$];
   int vecs = 0;
   int errs = 0;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Driver: push expectation, raise request, wait for done
   task automatic send(input logic [ROW_W-1:0] row, input bit ret, input logic [3:0] len);
      exp_t e;
      int b, s, m;
      @(negedge clk);
      while (busy_o) @(negedge clk);
      s = int'(row[1:0]);
      m = int'(row[6:2]);
      b = int'(row[8:7]);
      e.mwl = NMWL'(1) << m;
      e.blk = NBLK'(1) << b;
      e.sd  = ret ? (NSDT'(4'hF) << (b*4)) : (NSDT'(1) << (b*4 + s));
      e.len = (len == 0) ? 1 : int'(len);
      q.push_back(e);
      req_i = 1'b1; row_i = row; ret_mode_i = ret; pulse_len_i = len;
      @(negedge clk);
      req_i = 1'b0;
      while (!done_o) @(negedge clk);
   endtask

   // Monitor: pop expectation at the first wordline cycle, measure the pulse
   bit   mon_act = 1'b0;
   int   mon_len = 0;
   exp_t cur;
   always @(negedge clk) begin
      if (!rst_n) begin
         mon_act = 1'b0;
      end else if (!mon_act && mwl_o != '0) begin
         if (q.size() == 0) begin
            check(1'b0, "R8 unexpected pulse", 64'(mwl_o), 64'(0));
         end else begin
            cur = q.pop_front();
            check(mwl_o == cur.mwl, "R1/R2 main wordline", 64'(mwl_o), 64'(cur.mwl));
            check(sd_o == cur.sd, "R1/R4/R5 sub-decode", 64'(sd_o), 64'(cur.sd));
            check(blk_sel_o == cur.blk, "R3 block select", 64'(blk_sel_o), 64'(cur.blk));
            check(tg_l_o == cur.blk && tg_r_o == cur.blk, "R3 transfer gates",
                  64'({tg_l_o, tg_r_o}), 64'({cur.blk, cur.blk}));
         end
         mon_act = 1'b1;
         mon_len = 1;
      end else if (mon_act && mwl_o != '0) begin
         mon_len++;
      end else if (mon_act) begin
         mon_act = 1'b0;
         check(mon_len == cur.len, "R2 pulse length", 64'(mon_len), 64'(cur.len));
         check(done_o == 1'b1, "R8 done after pulse", 64'(done_o), 64'(1));
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      int s0, t0;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(mwl_o == 0 && sd_o == 0 && blk_sel_o == 0 && tg_l_o == 0 && tg_r_o == 0
            && !busy_o && !done_o && sd_tog_o == 0 && tg_tog_o == 0,
            "R10 reset outputs", 64'({sd_o, blk_sel_o, busy_o, done_o}), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // Normal mode: four accesses
      s0 = int'(sd_tog_o); t0 = int'(tg_tog_o);
      send(9'h000, 1'b0, 4'd3);
      check(sd_o == 0 && blk_sel_o == 0 && tg_l_o == 0 && tg_r_o == 0,
            "R4 controls low at done", 64'({sd_o, blk_sel_o}), 64'(0));
      send(9'h1FF, 1'b0, 4'd1);
      check(sd_o == 0 && blk_sel_o == 0, "R4 controls low at done", 64'({sd_o, blk_sel_o}), 64'(0));
      send(9'h0A5, 1'b0, 4'd0);
      send(9'h153, 1'b0, 4'd5);
      check(sd_o == 0 && tg_l_o == 0 && tg_r_o == 0, "R4 controls low at done",
            64'({sd_o, tg_l_o, tg_r_o}), 64'(0));
      @(negedge clk);
      check(int'(sd_tog_o) - s0 == 8, "R9 sub-decode toggles normal", 64'(int'(sd_tog_o) - s0), 64'(8));
      check(int'(tg_tog_o) - t0 == 16, "R9 gate toggles normal", 64'(int'(tg_tog_o) - t0), 64'(16));

      // Request while busy is ignored (R8)
      send(9'h064, 1'b0, 4'd4);
      @(negedge clk);
      begin
         exp_t e;
         e.mwl = NMWL'(1) << 7; e.blk = 4'b0010; e.sd = NSDT'(1) << 5; e.len = 4;
         q.push_back(e);
         req_i = 1'b1; row_i = 9'h09D; pulse_len_i = 4'd4; ret_mode_i = 1'b0;
         @(negedge clk);
         row_i = 9'h1E2;
         @(negedge clk);
         req_i = 1'b0;
         while (!done_o) @(negedge clk);
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(mwl_o == 0 && !busy_o, "R8 busy request ignored", 64'({mwl_o, busy_o}), 64'(0));
         end
         check(q.size() == 0, "R8 no extra access", 64'(q.size()), 64'(0));
      end

      // Retention: four refreshes in block 1
      s0 = int'(sd_tog_o); t0 = int'(tg_tog_o);
      send(9'h080, 1'b1, 4'd2);
      check(blk_sel_o == 4'b0010 && sd_o == 16'h00F0 && tg_l_o == 4'b0010 && tg_r_o == 4'b0010,
            "R5 held after done", 64'({sd_o, blk_sel_o}), 64'({16'h00F0, 4'b0010}));
      send(9'h081, 1'b1, 4'd2);
      send(9'h0C6, 1'b1, 4'd1);
      send(9'h0FF, 1'b1, 4'd2);
      check(blk_sel_o == 4'b0010 && sd_o == 16'h00F0, "R5 still held",
            64'({sd_o, blk_sel_o}), 64'({16'h00F0, 4'b0010}));
      @(negedge clk);
      check(int'(sd_tog_o) - s0 == 4, "R5/R9 sub-decode toggles retention", 64'(int'(sd_tog_o) - s0), 64'(4));
      check(int'(tg_tog_o) - t0 == 2, "R5/R9 gate toggles retention", 64'(int'(tg_tog_o) - t0), 64'(2));

      // Retention: block change
      s0 = int'(sd_tog_o); t0 = int'(tg_tog_o);
      send(9'h10A, 1'b1, 4'd3);
      check(blk_sel_o == 4'b0100 && sd_o == 16'h0F00 && tg_l_o == 4'b0100 && tg_r_o == 4'b0100,
            "R6 re-driven for new block", 64'({sd_o, blk_sel_o}), 64'({16'h0F00, 4'b0100}));
      @(negedge clk);
      check(int'(sd_tog_o) - s0 == 8, "R6/R9 sub-decode toggles block change", 64'(int'(sd_tog_o) - s0), 64'(8));
      check(int'(tg_tog_o) - t0 == 4, "R6/R9 gate toggles block change", 64'(int'(tg_tog_o) - t0), 64'(4));

      // Exit retention
      s0 = int'(sd_tog_o); t0 = int'(tg_tog_o);
      ret_mode_i = 1'b0;
      @(negedge clk);
      check(sd_o == 0 && blk_sel_o == 0 && tg_l_o == 0 && tg_r_o == 0, "R7 released on exit",
            64'({sd_o, blk_sel_o, tg_l_o, tg_r_o}), 64'(0));
      @(negedge clk);
      check(int'(sd_tog_o) - s0 == 4 && int'(tg_tog_o) - t0 == 2, "R7/R9 release toggles",
            64'({16'(int'(sd_tog_o) - s0), 16'(int'(tg_tog_o) - t0)}), 64'({16'd4, 16'd2}));

      // Normal access after exit
      send(9'h1A8, 1'b0, 4'd2);
      check(sd_o == 0 && blk_sel_o == 0, "R4 normal after exit", 64'({sd_o, blk_sel_o}), 64'(0));
      repeat (4) @(negedge clk);
      check(q.size() == 0, "R2 every access pulsed", 64'(q.size()), 64'(0));

      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule